// File: doc/BRIEF.md
# Flash Command Sequencer

This block runs one short serial-flash command at a time. Software composes the whole command in a single 32-bit control word: an opcode, whether an address goes out and how many bytes of it, a number of dummy cycles, and whether write data or read data follows, with up to eight bytes of each. Lengths are held as count-minus-one. Writing the control word with its execute bit set starts the command. The block then issues the bytes one at a time over a single-lane byte handshake toward a chip-select and serial-clock sequencer, and raises a busy flag until the command is finished.

The address comes from a separate 32-bit input register. Write data comes from two 32-bit registers. Received bytes are collected into two 32-bit read registers. The register inputs must stay stable while the command runs. A trigger that arrives while a command is running is dropped.

Top module: `fce_cmd_engine`

## Requirements
- R1: The opcode sits in control bits 31:24. It is always the first byte sent, and it goes out on the cycle right after the trigger is accepted.
- R2: Control bit 19 enables an address phase, and bits 17:16 hold the address byte count minus one (1 to 4 bytes). The address is sent most-significant byte first, and only the low N bytes of the address register are used.
- R3: Control bits 11:7 set a count D of idle cycles after the address phase, or after the opcode when there is no address. During these cycles no byte is started. With D not zero, the next start comes D+1 cycles after the previous byte-done instead of 1 cycle after it.
- R4: Control bit 15 enables a write phase, and bits 14:12 hold the byte count minus one (1 to 8). Bytes 1 to 4 come from the lower write register and bytes 5 to 8 from the upper one, least-significant byte first.
- R5: Control bit 23 enables a read phase, and bits 22:20 hold the byte count minus one. During this phase the bytes sent are 0x00. The received bytes fill lane 0 upward: lanes 0 to 3 go to the lower read register and lanes 4 to 7 to the upper one, least-significant byte first. An accepted trigger clears both read registers, so lanes that receive nothing read as zero.
- R6: The phases run in the order opcode, address, dummy, write, read, and a disabled phase is skipped.
- R7: A control write starts a command only when bit 0 is 1 and the block is idle. A control write with bit 0 at 0 starts nothing.
- R8: Busy reads 1 from the cycle after an accepted trigger. It returns to 0 one cycle after the last byte-done, or at the end of a dummy count that closes the command.
- R9: A control write while busy has no effect on the running command, and no command follows it.
- R10: The start strobe is a single-cycle pulse, with only one byte outstanding at a time. The transmitted byte holds steady until the matching byte-done.
- R11: After synchronous reset, busy, start and both read registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word; bit 0 is the execute trigger |
| addr_i | input | 32 | Command address register |
| wdata_lo_i | input | 32 | Write data bytes 1 to 4 |
| wdata_hi_i | input | 32 | Write data bytes 5 to 8 |
| rdata_lo_o | output | 32 | Read data bytes 1 to 4 |
| rdata_hi_o | output | 32 | Read data bytes 5 to 8 |
| busy_o | output | 1 | Command in progress |
| sh_start_o | output | 1 | Start one byte transfer |
| sh_tx_o | output | 8 | Byte to shift out |
| sh_rx_i | input | 8 | Byte shifted in |
| sh_done_i | input | 1 | Byte transfer finished |

## Verification
The bench covers phase-skipping combinations such as opcode-only, opcode plus dummy with nothing after it, and a write followed by a read. A design that chose the next phase wrongly would send extra bytes or stall. The one-byte and four-byte address counts catch a reversed or misaligned byte order. The eight-byte write and read cases catch a wrong switch between the lower and upper registers. Running a short read after a long read exposes stale upper bytes that were never cleared. The bench times the gap at the dummy point and the busy drop after a trailing dummy count, which catches off-by-one dummy counters. A trigger sent mid-command would, in a faulty design, restart or corrupt the byte stream.

// File: rtl/fce_pkg.sv
`timescale 1ns/1ps
package fce_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int MAX_BYTES = 8;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int DUMMY_W   = 5;
    localparam int AN_W      = 2;

    typedef struct packed {
        logic [BYTE_W-1:0]  opcode;
        logic               rd_en;
        logic [IDX_W-1:0]   rd_n;
        logic               addr_en;
        logic [AN_W-1:0]    addr_n;
        logic               wr_en;
        logic [IDX_W-1:0]   wr_n;
        logic [DUMMY_W-1:0] dummy;
    } cmd_t;

    typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_WR, PH_RD} phase_t;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DUMMY} state_t;

    function automatic cmd_t decode_ctrl(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.opcode  = w[31:24];
        c.rd_en   = w[23];
        c.rd_n    = w[22:20];
        c.addr_en = w[19];
        c.addr_n  = w[17:16];
        c.wr_en   = w[15];
        c.wr_n    = w[14:12];
        c.dummy   = w[11:7];
        return c;
    endfunction

    // Address goes out most-significant enabled byte first.
    function automatic logic [BYTE_W-1:0] addr_byte(input logic [WORD_W-1:0] a,
                                                    input logic [AN_W-1:0] n,
                                                    input logic [IDX_W-1:0] idx);
        logic [AN_W-1:0] sel;
        sel = n - idx[AN_W-1:0];
        return a[{sel, 3'b000} +: BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] data_byte(input logic [WORD_W-1:0] lo,
                                                    input logic [WORD_W-1:0] hi,
                                                    input logic [IDX_W-1:0] idx);
        logic [2*WORD_W-1:0] d;
        d = {hi, lo};
        return d[{idx, 3'b000} +: BYTE_W];
    endfunction
endpackage

// File: rtl/fce_rxpack.sv
`timescale 1ns/1ps
module fce_rxpack
    import fce_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic                 we_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [BYTE_W-1:0]    byte_i,
    output logic [WORD_W-1:0]    lo_o,
    output logic [WORD_W-1:0]    hi_o
);
    localparam int PACK_W = MAX_BYTES * BYTE_W;
    logic [PACK_W-1:0] pack;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || clr_i)
                lane_q <= '0;
            else if (we_i && idx_i == IDX_W'(g))
                lane_q <= byte_i;
        end
        assign pack[g*BYTE_W +: BYTE_W] = lane_q;
    end

    assign lo_o = pack[WORD_W-1:0];
    assign hi_o = pack[PACK_W-1:WORD_W];

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !we_i) |=> (lo_o == '0 && hi_o == '0));
endmodule

// File: rtl/fce_seq.sv
`timescale 1ns/1ps
module fce_seq
    import fce_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_i,
    input  logic [WORD_W-1:0]    ctrl_i,
    input  logic [WORD_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    wlo_i,
    input  logic [WORD_W-1:0]    whi_i,
    input  logic                 done_i,
    output logic                 start_o,
    output logic [BYTE_W-1:0]    tx_o,
    output logic                 busy_o,
    output logic                 rx_we_o,
    output logic [IDX_W-1:0]     rx_idx_o,
    output logic                 clr_o
);
    state_t              st_q;
    phase_t              ph_q;
    logic [IDX_W-1:0]    idx_q;
    logic [DUMMY_W-1:0]  dcnt_q;
    cmd_t                cmd_q;

    logic                accept;
    logic [IDX_W-1:0]    last_idx;
    logic                at_last;
    phase_t              post_ph, nx_ph;
    logic                post_done, nx_done, nx_dummy;

    assign accept = trig_i && ctrl_i[0] && (st_q == ST_IDLE);
    assign clr_o  = accept;

    always_comb begin
        case (ph_q)
            PH_OPC:  last_idx = '0;
            PH_ADDR: last_idx = IDX_W'(cmd_q.addr_n);
            PH_WR:   last_idx = cmd_q.wr_n;
            default: last_idx = cmd_q.rd_n;
        endcase
    end
    assign at_last = (idx_q == last_idx);

    // Phase that follows the dummy point.
    assign post_ph   = cmd_q.wr_en ? PH_WR : PH_RD;
    assign post_done = !cmd_q.wr_en && !cmd_q.rd_en;

    always_comb begin
        nx_ph    = post_ph;
        nx_done  = 1'b0;
        nx_dummy = 1'b0;
        case (ph_q)
            PH_OPC: begin
                if (cmd_q.addr_en)          nx_ph    = PH_ADDR;
                else if (cmd_q.dummy != '0) nx_dummy = 1'b1;
                else                        nx_done  = post_done;
            end
            PH_ADDR: begin
                if (cmd_q.dummy != '0) nx_dummy = 1'b1;
                else                   nx_done  = post_done;
            end
            PH_WR: begin
                if (cmd_q.rd_en) nx_ph   = PH_RD;
                else             nx_done = 1'b1;
            end
            default: nx_done = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_OPC;
            idx_q  <= '0;
            dcnt_q <= '0;
            cmd_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    cmd_q <= decode_ctrl(ctrl_i);
                    ph_q  <= PH_OPC;
                    idx_q <= '0;
                    st_q  <= ST_ISSUE;
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: if (done_i) begin
                    if (!at_last) begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_ISSUE;
                    end else begin
                        idx_q <= '0;
                        if (nx_dummy) begin
                            dcnt_q <= cmd_q.dummy;
                            st_q   <= ST_DUMMY;
                        end else if (nx_done) begin
                            st_q <= ST_IDLE;
                        end else begin
                            ph_q <= nx_ph;
                            st_q <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    if (dcnt_q == DUMMY_W'(1)) begin
                        if (post_done) st_q <= ST_IDLE;
                        else begin
                            ph_q <= post_ph;
                            st_q <= ST_ISSUE;
                        end
                    end else begin
                        dcnt_q <= dcnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (ph_q)
            PH_OPC:  tx_o = cmd_q.opcode;
            PH_ADDR: tx_o = addr_byte(addr_i, cmd_q.addr_n, idx_q);
            PH_WR:   tx_o = data_byte(wlo_i, whi_i, idx_q);
            default: tx_o = '0;
        endcase
    end

    assign start_o  = (st_q == ST_ISSUE);
    assign busy_o   = (st_q != ST_IDLE);
    assign rx_we_o  = (st_q == ST_WAIT) && done_i && (ph_q == PH_RD);
    assign rx_idx_o = idx_q;

    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);
    assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (trig_i && ctrl_i[0] && !busy_o) |=> (busy_o && start_o));
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i) |=> $stable(cmd_q));
    assert_opcode_first_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (start_o && tx_o == cmd_q.opcode));
endmodule

// File: rtl/fce_cmd_engine.sv
`timescale 1ns/1ps
module fce_cmd_engine
    import fce_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    input  logic [31:0] addr_i,
    input  logic [31:0] wdata_lo_i,
    input  logic [31:0] wdata_hi_i,
    output logic [31:0] rdata_lo_o,
    output logic [31:0] rdata_hi_o,
    output logic        busy_o,
    output logic        sh_start_o,
    output logic [7:0]  sh_tx_o,
    input  logic [7:0]  sh_rx_i,
    input  logic        sh_done_i
);
    logic             rx_we;
    logic [IDX_W-1:0] rx_idx;
    logic             clr;

    fce_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (ctrl_wr),
        .ctrl_i   (ctrl_wdata),
        .addr_i   (addr_i),
        .wlo_i    (wdata_lo_i),
        .whi_i    (wdata_hi_i),
        .done_i   (sh_done_i),
        .start_o  (sh_start_o),
        .tx_o     (sh_tx_o),
        .busy_o   (busy_o),
        .rx_we_o  (rx_we),
        .rx_idx_o (rx_idx),
        .clr_o    (clr)
    );

    fce_rxpack u_rx (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .we_i   (rx_we),
        .idx_i  (rx_idx),
        .byte_i (sh_rx_i),
        .lo_o   (rdata_lo_o),
        .hi_o   (rdata_hi_o)
    );
endmodule

// File: tb/fce_cmd_engine_test.sv
`timescale 1ns/1ps
module fce_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0, addr_i = '0, wdata_lo_i = '0, wdata_hi_i = '0;
    logic [31:0] rdata_lo_o, rdata_hi_o;
    logic        busy_o, sh_start_o, sh_done_i;
    logic [7:0]  sh_tx_o, sh_rx_i;

    always #2 clk = ~clk;

    fce_cmd_engine uut (.*);

    int n_chk = 0, n_fail = 0;
    int cyc = 0, nb = 0, fall_c = 0;
    logic prev_busy = 1'b0, tx_moved = 1'b0;
    logic [7:0] tx_log [32];
    int st_c [32];
    int dn_c [32];

    // {ctrl, addr, wdata_lo, wdata_hi}
    localparam logic [127:0] VEC [7] = '{
        {32'h06000001, 32'h00000000, 32'h00000000, 32'h00000000},
        {32'h0CFB0401, 32'h89ABCDEF, 32'h00000000, 32'h00000000},
        {32'h9FA00001, 32'h00000000, 32'h00000000, 32'h00000000},
        {32'h020A9001, 32'h00123456, 32'hDDCCBBAA, 32'h00000000},
        {32'h4200F001, 32'h00000000, 32'h44332211, 32'h88776655},
        {32'h5AC88181, 32'h000000A5, 32'h000000E7, 32'h00000000},
        {32'h31000281, 32'h00000000, 32'h00000000, 32'h00000000}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Flash-side responder: byte done two cycles after each start.
    initial begin
        sh_done_i = 1'b0;
        sh_rx_i   = '0;
        forever begin
            @(negedge clk);
            cyc++;
            sh_done_i = 1'b0;
            if (prev_busy && !busy_o) fall_c = cyc;
            prev_busy = busy_o;
            if (sh_start_o && nb < 32) begin
                tx_log[nb] = sh_tx_o;
                st_c[nb]   = cyc;
                for (int w = 0; w < 2; w++) begin
                    @(negedge clk);
                    cyc++;
                    if (sh_tx_o !== tx_log[nb]) tx_moved = 1'b1;
                end
                sh_rx_i   = 8'hC0 ^ nb[7:0];
                sh_done_i = 1'b1;
                dn_c[nb]  = cyc;
                nb++;
            end
        end
    end

    task automatic run_vec(input logic [31:0] c, input logic [31:0] a,
                           input logic [31:0] wl, input logic [31:0] wh,
                           input bit intrude);
        logic [7:0] e [32];
        int ne = 0, dpt = -1, rd0 = 0, tc, d, nr, ab, nw, guard;
        logic [63:0] erd = '0;
        bit ok;
        d  = int'(c[11:7]);
        nr = int'(c[22:20]) + 1;
        ab = int'(c[17:16]) + 1;
        nw = int'(c[14:12]) + 1;
        e[ne++] = c[31:24];
        if (c[19]) for (int j = 0; j < ab; j++) e[ne++] = a[8*(ab-1-j) +: 8];
        if (d != 0) dpt = ne;
        if (c[15]) for (int j = 0; j < nw; j++)
            e[ne++] = (j < 4) ? wl[8*j +: 8] : wh[8*(j-4) +: 8];
        rd0 = ne;
        if (c[23]) for (int j = 0; j < nr; j++) begin
            e[ne++] = 8'h00;
            erd[8*j +: 8] = 8'hC0 ^ 8'(rd0 + j);
        end

        @(negedge clk); #1;
        addr_i = a; wdata_lo_i = wl; wdata_hi_i = wh;
        nb = 0; tx_moved = 1'b0;
        ctrl_wdata = c; ctrl_wr = 1'b1; tc = cyc;
        @(negedge clk); #1;
        ctrl_wr = 1'b0;
        if (intrude) begin
            @(negedge clk); #1;
            ctrl_wdata = 32'hFF000001; ctrl_wr = 1'b1;
            @(negedge clk); #1;
            ctrl_wr = 1'b0;
        end
        guard = 0;
        while (busy_o && guard < 2000) begin
            @(negedge clk); guard++;
        end
        #1;

        chk(nb == ne, "R6", "byte count", 64'(nb), 64'(ne));
        ok = 1'b1;
        for (int k = 0; k < ne && k < nb; k++) if (tx_log[k] !== e[k]) ok = 1'b0;
        chk(ok, "R1/R2/R4/R5/R6", "tx byte stream", 64'(tx_log[0]), 64'(e[0]));
        chk(st_c[0] == tc + 1, "R7 R1", "first start cycle", 64'(st_c[0]), 64'(tc + 1));
        ok = 1'b1;
        for (int k = 1; k < ne && k < nb; k++)
            if (st_c[k] - dn_c[k-1] != ((k == dpt) ? d + 1 : 1)) ok = 1'b0;
        chk(ok, "R3 R10", "start spacing after done", 64'(ok), 64'(1));
        chk(!tx_moved, "R10", "tx stable until done", 64'(tx_moved), 64'(0));
        if (nb == ne)
            chk(fall_c == dn_c[ne-1] + 1 + ((dpt == ne) ? d : 0), "R8", "busy drop cycle",
                64'(fall_c), 64'(dn_c[ne-1] + 1 + ((dpt == ne) ? d : 0)));
        chk({rdata_hi_o, rdata_lo_o} === erd, "R5", "read registers",
            {rdata_hi_o, rdata_lo_o}, erd);
        if (intrude) begin
            repeat (10) @(negedge clk);
            #1;
            chk(nb == ne && !busy_o, "R9", "no command after busy trigger", 64'(nb), 64'(ne));
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk(!busy_o && !sh_start_o, "R11", "busy/start in reset", {busy_o, sh_start_o}, 0);
        chk(rdata_lo_o == 0 && rdata_hi_o == 0, "R11", "read regs in reset",
            {rdata_hi_o, rdata_lo_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 7; i++)
            run_vec(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], 1'b0);

        // R7: execute bit clear starts nothing
        @(negedge clk); #1;
        nb = 0;
        ctrl_wdata = 32'h9FA00000; ctrl_wr = 1'b1;
        @(negedge clk); #1;
        ctrl_wr = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        chk(nb == 0 && !busy_o, "R7", "no start without execute bit", 64'(nb), 0);

        // R9: trigger while busy is dropped
        run_vec(32'h020A9001, 32'h00123456, 32'hDDCCBBAA, 32'h0, 1'b1);

        summary();
        $finish;
    end
endmodule